// File: doc/BRIEF.md
# Time-Hopping Pulse-Position Scheduler

This block is the digital timing core of an impulse-radio transmitter. A fast tick clock is divided by a power of two into frames. Inside each frame a single pulse slot is opened. A 4-bit pseudo-random register chooses one of eight coarse slot positions. The data bit then either leaves that position alone or pushes it later by a fine step. Delay lines are modelled as whole tick counts.

From that final trigger tick the block drives two outputs. The first is a short pulse. The second is a wider gate pulse. Both are built by identical level-to-pulse paths, so they start on the same tick. Data enters through a valid/ready port that takes at most one bit per frame. The port is open on only one tick per frame, the last one. A sender that raises `bit_valid` earlier is back-pressured and must hold `bit_data` steady until the transfer tick. A frame that had no transfer emits no pulse.

The configuration must satisfy 7*HOP_STEP + PPM_STEP + GATE_W <= 2**DIV_BITS. This guarantees that every pulse ends inside its own frame.

Top module: `thppm_scheduler`

## Requirements
- R1: While `rst_n` is low, `short_pulse`, `gate_pulse` and `bit_ready` are low and `frame_start` is high. The phase is 0 and the pseudo-random state is 4'b1000 (bit 3 down to bit 0).
- R2: `frame_start` is high on exactly one tick in every 2**DIV_BITS ticks. That tick is phase 0, counted from reset. `bit_ready` is high on exactly the last tick of each frame.
- R3: The pseudo-random state advances on every clock edge at which the phase is odd, giving half the tick rate. The next state is {s[2:0], s[3]^s[2]}, which is maximal length with period 15, and the state is never zero.
- R4: The hop number of a frame is bits [2:0] of the pseudo-random state during the last tick of the previous frame. It is held for the whole frame.
- R5: A bit is transferred only on a tick where both `bit_valid` and `bit_ready` are high. It applies to the next frame. A frame that follows a last tick with no transfer emits no pulse on either output.
- R6: In a frame that has a bit, the pulse starts at tick hop*HOP_STEP + bit*PPM_STEP, counting the `frame_start` tick as tick 0.
- R7: `short_pulse` is high for exactly SHORT_W consecutive ticks and `gate_pulse` for exactly GATE_W consecutive ticks. Both rise on the start tick, and `short_pulse` is never high while `gate_pulse` is low.
- R8: At the latest slot (hop 7, bit 1), the gate pulse still ends on or before the last tick of its frame.
- R9: The frame that begins at reset emits no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Sender offers a data bit |
| bit_data | input | 1 | Data bit: 0 keeps the hop position, 1 adds the fine shift |
| bit_ready | output | 1 | High on the last tick of each frame; transfer happens when valid is also high |
| frame_start | output | 1 | One-tick frame strobe (phase 0) |
| short_pulse | output | 1 | Short output pulse, SHORT_W ticks |
| gate_pulse | output | 1 | Gate output pulse, GATE_W ticks |

## Verification
The bench builds the block with DIV_BITS=4, HOP_STEP=1, PPM_STEP=1, SHORT_W=2 and GATE_W=8. With these values the latest slot (hop 7, bit 1) places the gate pulse exactly on the final tick of a 16-tick frame, so the frame-boundary case is hit. A short width of 2 confirms that the width is counted rather than a single-tick edge. Over 40 frames the pseudo-random sequence wraps more than twice, so every hop value appears. Frames with no offered bit, and bits that are offered 15 ticks before the port opens, are both covered.

// File: rtl/thppm_pkg.sv
package thppm_pkg;
  localparam int PN_W      = 4;
  localparam int HOP_W     = 3;
  localparam int HOP_SLOTS = 1 << HOP_W;
  localparam logic [PN_W-1:0] PN_SEED = 4'b1000;

  // x^4 + x^3 + 1, shifted toward the MSB
  function automatic logic [PN_W-1:0] pn_advance(input logic [PN_W-1:0] s);
    return {s[2:0], s[3] ^ s[2]};
  endfunction
endpackage

// File: rtl/thppm_phase_ctr.sv
module thppm_phase_ctr #(
  parameter int DIV_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [DIV_BITS-1:0] phase,
  output logic                frame_start,
  output logic                last_tick
);
  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  assign frame_start = (phase == '0);
  assign last_tick   = &phase;

  // R2
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  // R2
  ready_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> frame_start);
endmodule

// File: rtl/thppm_pn_gen.sv
module thppm_pn_gen
  import thppm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [HOP_W-1:0] hop
);
  logic [PN_W-1:0] state;

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= PN_SEED;
    else if (step) state <= pn_advance(state);
  end

  assign hop = state[HOP_W-1:0];

  // R3
  pn_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  // R3
  pn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));
endmodule

// File: rtl/thppm_slot_sel.sv
module thppm_slot_sel
  import thppm_pkg::*;
#(
  parameter int HOP_STEP = 2,
  parameter int PPM_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [HOP_W-1:0] hop,
  input  logic             data,
  output logic             trig_edge
);
  localparam int LINE = (HOP_SLOTS - 1) * HOP_STEP;

  // coarse delay line of the frame strobe
  logic [LINE:1] tap_q;
  logic [LINE:0] tap;
  assign tap = {tap_q, frame_start};

  always_ff @(posedge clk) begin
    if (!rst_n) tap_q <= '0;
    else        tap_q <= tap[LINE-1:0];
  end

  logic [HOP_SLOTS-1:0] slot;
  for (genvar k = 0; k < HOP_SLOTS; k++) begin : g_taps
    assign slot[k] = tap[k*HOP_STEP];
  end

  logic coarse;
  assign coarse = slot[hop];

  // fine delay for the data shift
  logic [PPM_STEP:1] fin_q;
  logic [PPM_STEP:0] fin;
  assign fin = {fin_q, coarse};

  always_ff @(posedge clk) begin
    if (!rst_n) fin_q <= '0;
    else        fin_q <= fin[PPM_STEP-1:0];
  end

  assign trig_edge = data ? fin[PPM_STEP] : coarse;

  // R6
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot));
endmodule

// File: rtl/thppm_edge_pulse.sv
module thppm_edge_pulse #(
  parameter int WIDTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic level,
  output logic pulse
);
  logic [WIDTH:1] dly_q;
  logic [WIDTH:0] dly;
  assign dly = {dly_q, level};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) dly_q <= '0;
    else               dly_q <= dly[WIDTH-1:0];
  end

  // level compared with its own delayed copy
  assign pulse = level & ~dly[WIDTH];
endmodule

// File: rtl/thppm_scheduler.sv
module thppm_scheduler
  import thppm_pkg::*;
#(
  parameter int DIV_BITS = 5,
  parameter int HOP_STEP = 2,
  parameter int PPM_STEP = 1,
  parameter int SHORT_W  = 1,
  parameter int GATE_W   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  output logic bit_ready,
  output logic frame_start,
  output logic short_pulse,
  output logic gate_pulse
);
  logic [DIV_BITS-1:0] phase;
  logic                last_tick;
  logic [HOP_W-1:0]    hop_now;
  logic [HOP_W-1:0]    hop_q;
  logic                data_q;
  logic                fire_q;
  logic                raw_edge;
  logic                trig_hold;
  logic                trig;

  thppm_phase_ctr #(.DIV_BITS(DIV_BITS)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .frame_start(frame_start), .last_tick(last_tick));

  thppm_pn_gen u_pn (
    .clk(clk), .rst_n(rst_n), .step(phase[0]), .hop(hop_now));

  assign bit_ready = last_tick;

  // per-frame capture at the frame boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hop_q  <= '0;
      data_q <= 1'b0;
      fire_q <= 1'b0;
    end else if (last_tick) begin
      hop_q  <= hop_now;
      data_q <= bit_data & bit_valid;
      fire_q <= bit_valid;
    end
  end

  thppm_slot_sel #(.HOP_STEP(HOP_STEP), .PPM_STEP(PPM_STEP)) u_slot (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .hop(hop_q), .data(data_q), .trig_edge(raw_edge));

  assign trig = trig_hold | (raw_edge & fire_q);

  always_ff @(posedge clk) begin
    if (!rst_n || last_tick) trig_hold <= 1'b0;
    else                     trig_hold <= trig;
  end

  thppm_edge_pulse #(.WIDTH(SHORT_W)) u_short (
    .clk(clk), .rst_n(rst_n), .clr(last_tick), .level(trig), .pulse(short_pulse));

  thppm_edge_pulse #(.WIDTH(GATE_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .clr(last_tick), .level(trig), .pulse(gate_pulse));

  // R4
  hop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_ready |=> ($stable(hop_q) && $stable(data_q) && $stable(fire_q)));
  // R7
  short_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_pulse |-> gate_pulse);
  // R7
  aligned_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_pulse) |-> gate_pulse);
  // R5
  idle_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_q && !trig_hold) |-> !gate_pulse);
endmodule

// File: tb/tb_thppm_scheduler.sv
module tb_thppm_scheduler;
  localparam int DIV_BITS = 4;
  localparam int HOP_STEP = 1;
  localparam int PPM_STEP = 1;
  localparam int SHORT_W  = 2;
  localparam int GATE_W   = 8;
  localparam int FRAME    = 1 << DIV_BITS;
  localparam int NF       = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic bit_ready, frame_start, short_pulse, gate_pulse;

  int checks = 0;
  int fails = 0;
  int mon_frames = 0;
  bit done = 1'b0;
  logic [4:0] expq[$];

  always #5 clk = ~clk;

  thppm_scheduler #(.DIV_BITS(DIV_BITS), .HOP_STEP(HOP_STEP), .PPM_STEP(PPM_STEP),
                    .SHORT_W(SHORT_W), .GATE_W(GATE_W)) dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .frame_start(frame_start),
    .short_pulse(short_pulse), .gate_pulse(gate_pulse));

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic logic [3:0] ref_next(input logic [3:0] s);
    return {s[2:0], s[3] ^ s[2]};
  endfunction

  // driver: one offer per frame, raised at frame start and held (back-pressure)
  task automatic drive_frames();
    logic [3:0] r = 4'b1000;
    for (int i = 0; i < FRAME/2 - 1; i++) r = ref_next(r);
    for (int n = 1; n <= NF; n++) begin
      logic [2:0] hop;
      bit fire, d;
      hop  = r[2:0];
      fire = (n % 6) != 4;
      d    = (hop == 3'd7) ? 1'b1 : (((n * 5) % 3) == 1);
      do @(negedge clk); while (!frame_start);
      bit_valid = fire;
      bit_data  = d;
      do @(negedge clk); while (!bit_ready);
      expq.push_back({fire, hop, d});
      @(posedge clk);
      #1;
      bit_valid = 1'b0;
      bit_data  = 1'b0;
      for (int i = 0; i < FRAME/2; i++) r = ref_next(r);
    end
  endtask

  task automatic finish_frame(input int s_first, input int s_cnt, input int g_first,
                              input int g_cnt, input int last_t, input bit ready_bad);
    logic [4:0] it;
    int pos;
    check(last_t == FRAME - 1, "R2 frame length", last_t + 1, FRAME);
    check(!ready_bad, "R2 ready on last tick only", ready_bad, 0);
    if (expq.size() == 0) begin
      check(1'b0, "R5 expected item missing", 0, 1);
      return;
    end
    it = expq.pop_front();
    if (!it[4]) begin
      if (mon_frames == 0) check(s_cnt == 0 && g_cnt == 0, "R9 reset frame silent", g_cnt, 0);
      else check(s_cnt == 0 && g_cnt == 0, "R5 idle frame silent", g_cnt, 0);
    end else begin
      pos = int'(it[3:1]) * HOP_STEP + int'(it[0]) * PPM_STEP;
      check(s_first == pos, "R6 R3 R4 short start", s_first, pos);
      check(s_cnt == SHORT_W, "R7 short width", s_cnt, SHORT_W);
      check(g_first == pos, "R7 gate start", g_first, pos);
      check(g_cnt == GATE_W, "R7 gate width", g_cnt, GATE_W);
      if (it[3:1] == 3'd7 && it[0])
        check(g_first + g_cnt <= FRAME, "R8 latest slot ends in frame", g_first + g_cnt, FRAME);
    end
  endtask

  task automatic monitor();
    int t = 0, s_first = -1, s_cnt = 0, g_first = -1, g_cnt = 0;
    bit started = 1'b0, ready_bad = 1'b0;
    forever begin
      @(negedge clk);
      if (frame_start) begin
        if (started) begin
          finish_frame(s_first, s_cnt, g_first, g_cnt, t, ready_bad);
          mon_frames++;
        end
        started = 1'b1;
        t = 0; s_first = -1; s_cnt = 0; g_first = -1; g_cnt = 0; ready_bad = 1'b0;
      end else t++;
      if (bit_ready != (t == FRAME - 1)) ready_bad = 1'b1;
      if (short_pulse) begin
        if (s_first < 0) s_first = t;
        s_cnt++;
      end
      if (gate_pulse) begin
        if (g_first < 0) g_first = t;
        g_cnt++;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!short_pulse && !gate_pulse, "R1 pulses low in reset", short_pulse, 0);
    check(!bit_ready, "R1 ready low in reset", bit_ready, 0);
    check(frame_start, "R1 strobe high in reset", frame_start, 1);
    @(posedge clk);
    #2 rst_n = 1'b1;
    expq.push_back(5'b0);
    fork
      drive_frames();
      monitor();
    join_none
    wait (mon_frames == NF + 1);
    done = 1'b1;
    check(expq.size() == 0, "R5 all frames consumed", expq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", mon_frames, NF + 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule